// File: doc/BRIEF.md
# Byte-Wide Event Counter Bank

This block holds a small set of event counters, each 8, 16 or 24 bits wide, that a microprocessor reads over an 8-bit register bus. A counter advances by one on each clock where its event input is high and its enable bit is set. A counter that passes its all-ones value wraps to zero and raises a sticky overflow flag. Each counter also has two programmable thresholds. When an increment makes the count equal to a threshold, the matching sticky flag is set.

A bus read of a counter returns only its low byte. The same read copies bits 15:8 and 23:16 of that counter into a shared two-byte snapshot, and software then reads the upper bytes from the snapshot. The full value is therefore taken at a single instant. Each counter has two addresses. One address leaves the counter as it is. The other, an alias, clears the counter after the read.

Top module: `cbk_counter_bank`

## Requirements
- R1: After reset, all counters, enable bits, thresholds, snapshot bytes, interrupt flags and `bus_rdata` are zero.
- R2: Counter k counts one per clock when `cnt_evt[k]` is high and its enable bit is set. The enable bit for counter k is bit k%8 of the register at address 2 + k/8. Enable registers can be written and read, and bits with no counter read as 0.
- R3: A read (`bus_en`=1, `bus_we`=0) of counter i's base address 5+2i puts the counter's low byte on `bus_rdata` one clock later and leaves the counter unchanged. Every read updates `bus_rdata` this way, and `bus_rdata` holds its value between reads.
- R4: A read of the alias address 4+2i returns the same low byte and clears counter i at that clock edge. An event counted in the same clock leaves the counter at 1.
- R5: A read of either counter address copies counter bits 15:8 into the snapshot byte at address 0 and bits 23:16 into the snapshot byte at address 1. The copy uses the value from before any clear. Bytes above the counter width are taken as 0.
- R6: Writes to counter addresses and snapshot addresses change nothing.
- R7: Counter i is 24 bits wide when i%3==0, 16 bits when i%3==1 and 8 bits when i%3==2. An increment from all ones wraps the counter to 0 and sets `irq_ovf[i]`.
- R8: Threshold t (0 or 1) of counter i is held as bytes at address 0x20+8i+4t+b, with b=0 the least significant byte. Bytes b at or above the counter's byte width read 0 and ignore writes.
- R9: `irq_th0[i]` / `irq_th1[i]` is set when an increment, without wrap, makes the count equal to threshold 0 / 1. A threshold of 0 never sets its flag.
- R10: Each flag stays set until its bit in `ovf_clr`, `th0_clr` or `th1_clr` is high for a clock. A set in the same clock takes priority over the clear.
- R11: A counter whose enable bit is clear keeps its value, apart from an alias-read clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access request for this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the clock after a read |
| cnt_evt | input | NUM_CNT | Per-counter event inputs |
| ovf_clr | input | NUM_CNT | Clears overflow flags |
| th0_clr | input | NUM_CNT | Clears threshold-0 flags |
| th1_clr | input | NUM_CNT | Clears threshold-1 flags |
| irq_ovf | output | NUM_CNT | Sticky overflow flags |
| irq_th0 | output | NUM_CNT | Sticky threshold-0 crossing flags |
| irq_th1 | output | NUM_CNT | Sticky threshold-1 crossing flags |

## Verification
A wrong count is visible at the ports only when software reads the counter. It then appears one clock after that read, in the low byte, or in the snapshot bytes on the next snapshot read. The overflow and threshold flags expose a corrupted count much earlier, in the clock after the increment that should, or should not, have hit all ones or a threshold. A bad snapshot copy or a bad clear-on-read stays hidden until a second read. For that reason the checks read the same counter back through both of its addresses and through both snapshot bytes.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
  localparam int MAX_BYTES = 3;
  localparam int WORD_W    = 8 * MAX_BYTES;
  typedef logic [WORD_W-1:0] word_t;

  localparam logic [7:0] ADDR_SNAP_MID = 8'h00;
  localparam logic [7:0] ADDR_SNAP_HI  = 8'h01;
  localparam logic [7:0] ADDR_EN_BASE  = 8'h02;
  localparam int         CNT_BASE      = 4;
  localparam int         THR_BASE      = 32;

  // byte width of counter idx: 24, 16, 8, 24, ...
  function automatic int cnt_bytes(input int idx);
    return MAX_BYTES - (idx % MAX_BYTES);
  endfunction

  function automatic word_t width_mask(input int bytes);
    logic [31:0] m;
    m = (32'd1 << (8 * bytes)) - 32'd1;
    return m[WORD_W-1:0];
  endfunction

  function automatic logic [7:0] alias_addr(input int idx);
    return 8'(CNT_BASE + 2 * idx);
  endfunction

  function automatic logic [7:0] base_addr(input int idx);
    return 8'(CNT_BASE + 2 * idx + 1);
  endfunction

  function automatic logic [7:0] thr_addr(input int idx, input int t, input int b);
    return 8'(THR_BASE + 8 * idx + 4 * t + b);
  endfunction

  // value the counter starts the clock from (after an optional clear)
  function automatic word_t start_value(input word_t cur, input logic clr);
    return clr ? '0 : cur;
  endfunction

  function automatic word_t step(input word_t cur, input logic clr,
                                 input logic inc, input word_t mask);
    return (start_value(cur, clr) + word_t'(inc)) & mask;
  endfunction
endpackage

// File: rtl/cbk_flag.sv
module cbk_flag #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= set | (q & ~clr);
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set))); // R10
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|q) |=> ((~q & $past(q) & ~$past(clr)) == '0)); // R10
endmodule

// File: rtl/cbk_counter.sv
module cbk_counter
  import cbk_pkg::*;
#(
  parameter int BYTES = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  inc,
  input  logic  clr,
  input  word_t thr0,
  input  word_t thr1,
  output word_t value,
  output logic  ovf_evt,
  output logic  th0_evt,
  output logic  th1_evt
);
  localparam int    CW   = 8 * BYTES;
  localparam word_t MASK = width_mask(BYTES);

  logic [CW-1:0] cnt_q;
  word_t         nxt_w;

  always_comb begin
    value         = '0;
    value[CW-1:0] = cnt_q;
  end

  assign nxt_w   = step(value, clr, inc, MASK);
  assign ovf_evt = inc && (start_value(value, clr) == MASK);
  assign th0_evt = inc && !ovf_evt && (nxt_w == (thr0 & MASK));
  assign th1_evt = inc && !ovf_evt && (nxt_w == (thr1 & MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_w[CW-1:0];
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> (value == $past(value))); // R11
  AST_CLR_EVT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && inc) |=> (value == word_t'(1))); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (value == '0)); // R7
  AST_THR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    th0_evt |=> (value == ($past(thr0) & MASK))); // R9
endmodule

// File: rtl/cbk_counter_bank.sv
module cbk_counter_bank
  import cbk_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_CNT-1:0] cnt_evt,
  input  logic [NUM_CNT-1:0] ovf_clr,
  input  logic [NUM_CNT-1:0] th0_clr,
  input  logic [NUM_CNT-1:0] th1_clr,
  output logic [NUM_CNT-1:0] irq_ovf,
  output logic [NUM_CNT-1:0] irq_th0,
  output logic [NUM_CNT-1:0] irq_th1
);
  localparam int NUM_THR = 2;

  logic rd_req, wr_req, cnt_rd_any;
  logic [NUM_CNT-1:0] hit_base, hit_alias, cnt_clr, inc_vec;
  logic [NUM_CNT-1:0] ovf_evt, th0_evt, th1_evt;
  logic [NUM_CNT-1:0] en_q;
  word_t cnt_val [NUM_CNT];
  word_t thr_q   [NUM_CNT][NUM_THR];
  word_t sel_val;
  logic [7:0] snap_mid, snap_hi, rd_mux;

  assign rd_req     = bus_en && !bus_we;
  assign wr_req     = bus_en && bus_we;
  assign cnt_rd_any = rd_req && (|(hit_base | hit_alias));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int BYTES = cnt_bytes(i);
    assign hit_base[i]  = (bus_addr == base_addr(i));
    assign hit_alias[i] = (bus_addr == alias_addr(i));
    assign cnt_clr[i]   = rd_req && hit_alias[i];
    assign inc_vec[i]   = en_q[i] && cnt_evt[i];

    cbk_counter #(.BYTES(BYTES)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc_vec[i]),
      .clr     (cnt_clr[i]),
      .thr0    (thr_q[i][0]),
      .thr1    (thr_q[i][1]),
      .value   (cnt_val[i]),
      .ovf_evt (ovf_evt[i]),
      .th0_evt (th0_evt[i]),
      .th1_evt (th1_evt[i])
    );

    AST_WR_CNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && (hit_base[i] || hit_alias[i]) && !inc_vec[i])
        |=> $stable(cnt_val[i])); // R6
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[i] && !cnt_clr[i]) |=> $stable(cnt_val[i])); // R11
    AST_ALIAS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr[i] && !inc_vec[i]) |=> (cnt_val[i] == '0)); // R4
    AST_OVF_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt[i] |=> irq_ovf[i]); // R7
  end

  // read mux: registers, counter low bytes, threshold bytes
  always_comb begin
    rd_mux  = '0;
    sel_val = '0;
    if (bus_addr == ADDR_SNAP_MID) rd_mux = snap_mid;
    if (bus_addr == ADDR_SNAP_HI)  rd_mux = snap_hi;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (bus_addr == 8'(ADDR_EN_BASE + 8'(k / 8))) rd_mux[k % 8] = en_q[k];
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (hit_base[i] || hit_alias[i]) begin
        rd_mux  = cnt_val[i][7:0];
        sel_val = cnt_val[i];
      end
      for (int t = 0; t < NUM_THR; t++) begin
        for (int b = 0; b < MAX_BYTES; b++) begin
          if (bus_addr == thr_addr(i, t, b))
            rd_mux = (b < cnt_bytes(i)) ? thr_q[i][t][8*b +: 8] : 8'h00;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      snap_mid  <= '0;
      snap_hi   <= '0;
    end else if (rd_req) begin
      bus_rdata <= rd_mux;
      if (cnt_rd_any) begin
        snap_mid <= sel_val[15:8];
        snap_hi  <= sel_val[23:16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NUM_CNT; i++)
        for (int t = 0; t < NUM_THR; t++) thr_q[i][t] <= '0;
    end else if (wr_req) begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if (bus_addr == 8'(ADDR_EN_BASE + 8'(k / 8))) en_q[k] <= bus_wdata[k % 8];
      end
      for (int i = 0; i < NUM_CNT; i++)
        for (int t = 0; t < NUM_THR; t++)
          for (int b = 0; b < MAX_BYTES; b++)
            if (bus_addr == thr_addr(i, t, b) && b < cnt_bytes(i))
              thr_q[i][t][8*b +: 8] <= bus_wdata;
    end
  end

  cbk_flag #(.N(NUM_CNT)) u_ovf (.clk(clk), .rst_n(rst_n), .set(ovf_evt), .clr(ovf_clr), .q(irq_ovf));
  cbk_flag #(.N(NUM_CNT)) u_th0 (.clk(clk), .rst_n(rst_n), .set(th0_evt), .clr(th0_clr), .q(irq_th0));
  cbk_flag #(.N(NUM_CNT)) u_th1 (.clk(clk), .rst_n(rst_n), .set(th1_evt), .clr(th1_clr), .q(irq_th1));

  AST_RD_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_any |=> (bus_rdata == $past(sel_val[7:0]))); // R3
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd_any |=> (snap_mid == $past(sel_val[15:8]) && snap_hi == $past(sel_val[23:16]))); // R5
  AST_WR_SNAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bus_addr < ADDR_EN_BASE) |=> ($stable(snap_mid) && $stable(snap_hi))); // R6
endmodule

// File: tb/cbk_counter_bank_test.sv
module cbk_counter_bank_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [N-1:0] cnt_evt = '0, ovf_clr = '0, th0_clr = '0, th1_clr = '0;
  logic [N-1:0] irq_ovf, irq_th0, irq_th1;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cbk_counter_bank #(.NUM_CNT(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_evt(cnt_evt), .ovf_clr(ovf_clr), .th0_clr(th0_clr), .th1_clr(th1_clr),
    .irq_ovf(irq_ovf), .irq_th0(irq_th0), .irq_th1(irq_th1)
  );

  // ---------------- bench-side reference ----------------
  function automatic int nbytes(input int i);
    case (i % 3)
      0: return 3;
      1: return 2;
      default: return 1;
    endcase
  endfunction
  function automatic int top_val(input int i);
    return (1 << (8 * nbytes(i))) - 1;
  endfunction

  int m_cnt [N];
  int m_thr [N][2];
  logic [N-1:0] m_en, m_ovf, m_th0, m_th1;
  logic [7:0] m_mid, m_hi, m_rdata;
  string last_tag = "R1";

  function automatic logic [7:0] view(input logic [7:0] a);
    int off;
    if (a == 8'd0) return m_mid;
    if (a == 8'd1) return m_hi;
    if (a == 8'd2) return {4'b0, m_en};
    if (a >= 8'd4 && a < 8'd4 + 8'(2*N)) return 8'(m_cnt[(int'(a) - 4) / 2]);
    if (a >= 8'h20 && a < 8'h20 + 8'(8*N)) begin
      off = int'(a) - 32;
      if ((off % 4) >= nbytes(off / 8)) return 8'h00;
      return 8'(m_thr[off / 8][(off / 4) % 2] >> (8 * (off % 4)));
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a < 8'd2) return "R5";
    if (a < 8'd4) return "R2";
    if (a < 8'd4 + 8'(2*N)) return a[0] ? "R3" : "R4";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_cnt[i] = 0; m_thr[i][0] = 0; m_thr[i][1] = 0;
      end
      m_en = '0; m_ovf = '0; m_th0 = '0; m_th1 = '0;
      m_mid = '0; m_hi = '0; m_rdata = '0;
    end else begin
      bit rd, wr;
      rd = bus_en && !bus_we;
      wr = bus_en && bus_we;
      if (rd) begin
        m_rdata = view(bus_addr);
        last_tag = tag_of(bus_addr);
        for (int i = 0; i < N; i++)
          if (int'(bus_addr) == 4 + 2*i || int'(bus_addr) == 5 + 2*i) begin
            m_mid = 8'(m_cnt[i] >> 8);
            m_hi  = 8'(m_cnt[i] >> 16);
          end
      end
      for (int i = 0; i < N; i++) begin
        int b, nx;
        bit s_o, s_0, s_1;
        b = (rd && int'(bus_addr) == 4 + 2*i) ? 0 : m_cnt[i];
        s_o = 0; s_0 = 0; s_1 = 0;
        nx = b;
        if (m_en[i] && cnt_evt[i]) begin
          if (b == top_val(i)) begin nx = 0; s_o = 1; end
          else begin
            nx = b + 1;
            s_0 = (nx == m_thr[i][0]);
            s_1 = (nx == m_thr[i][1]);
          end
        end
        m_cnt[i] = nx;
        m_ovf[i] = s_o | (m_ovf[i] & ~ovf_clr[i]);
        m_th0[i] = s_0 | (m_th0[i] & ~th0_clr[i]);
        m_th1[i] = s_1 | (m_th1[i] & ~th1_clr[i]);
      end
      if (wr) begin
        if (bus_addr == 8'd2) m_en = bus_wdata[N-1:0];
        if (bus_addr >= 8'h20 && bus_addr < 8'h20 + 8'(8*N)) begin
          int off, ci, ti, bi;
          off = int'(bus_addr) - 32;
          ci = off / 8; ti = (off / 4) % 2; bi = off % 4;
          if (bi < nbytes(ci))
            m_thr[ci][ti] = (m_thr[ci][ti] & ~(255 << (8*bi))) | (int'(bus_wdata) << (8*bi));
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(bus_rdata == m_rdata, last_tag, bus_rdata, m_rdata);
      chk(irq_ovf == m_ovf, "R7", irq_ovf, m_ovf);
      chk(irq_th0 == m_th0, "R9", irq_th0, m_th0);
      chk(irq_th1 == m_th1, "R9", irq_th1, m_th1);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic pulse(input logic [N-1:0] m, input int n);
    @(negedge clk);
    cnt_evt = m;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    cnt_evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;

    // R1: reset state
    rd(8'd5, d);  chk(d == 8'h00, "R1", d, 0);
    rd(8'd0, d);  chk(d == 8'h00, "R1", d, 0);
    chk(irq_ovf == 0 && irq_th0 == 0 && irq_th1 == 0, "R1", irq_ovf, 0);

    // R2: enable register readback, unused bits zero
    wr(8'd2, 8'hFF); rd(8'd2, d); chk(d == 8'h0F, "R2", d, 8'h0F);
    wr(8'd3, 8'hFF); rd(8'd3, d); chk(d == 8'h00, "R2", d, 0);
    wr(8'd2, 8'h01);

    // R2/R11: only counter 0 counts, 300 events
    pulse(4'b0011, 300);
    rd(8'd5, d); chk(d == 8'h2C, "R3", d, 8'h2C);
    rd(8'd0, d); chk(d == 8'h01, "R5", d, 8'h01);
    rd(8'd1, d); chk(d == 8'h00, "R5", d, 0);
    rd(8'd5, d); chk(d == 8'h2C, "R3", d, 8'h2C);
    rd(8'd7, d); chk(d == 8'h00, "R11", d, 0);

    // R4: alias read with an event in the same clock
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 8'd4; cnt_evt = 4'b0001;
    @(negedge clk);
    bus_en = 0; cnt_evt = '0;
    chk(bus_rdata == 8'h2C, "R4", bus_rdata, 8'h2C);
    rd(8'd0, d); chk(d == 8'h01, "R5", d, 8'h01);
    rd(8'd5, d); chk(d == 8'h01, "R4", d, 1);

    // R6: writes to counter and snapshot addresses ignored
    wr(8'd5, 8'h55); wr(8'd4, 8'h66); wr(8'd0, 8'h77);
    rd(8'd0, d); chk(d == 8'h00, "R6", d, 0);
    rd(8'd5, d); chk(d == 8'h01, "R6", d, 1);

    // R7: 8-bit counter 2 wraps after 256 events
    wr(8'd2, 8'h04);
    pulse(4'b0100, 255);
    chk(irq_ovf[2] == 1'b0, "R7", irq_ovf[2], 0);
    pulse(4'b0100, 1);
    chk(irq_ovf[2] == 1'b1, "R7", irq_ovf[2], 1);
    rd(8'd9, d); chk(d == 8'h00, "R7", d, 0);

    // R10: flag clear
    @(negedge clk); ovf_clr = 4'b0100;
    @(negedge clk); ovf_clr = '0;
    chk(irq_ovf[2] == 1'b0, "R10", irq_ovf[2], 0);

    // R8/R9: threshold 0 of 16-bit counter 1 set to 5
    wr(8'h2A, 8'h77); rd(8'h2A, d); chk(d == 8'h00, "R8", d, 0);
    wr(8'h28, 8'h05); rd(8'h28, d); chk(d == 8'h05, "R8", d, 5);
    wr(8'd2, 8'h02);
    pulse(4'b0010, 4);
    chk(irq_th0[1] == 1'b0, "R9", irq_th0[1], 0);
    pulse(4'b0010, 1);
    chk(irq_th0[1] == 1'b1, "R9", irq_th0[1], 1);

    // random phase against the bench model
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int op;
      @(negedge clk);
      cnt_evt = N'($urandom);
      ovf_clr = ($urandom % 16 == 0) ? N'($urandom) : '0;
      th0_clr = ($urandom % 16 == 0) ? N'($urandom) : '0;
      th1_clr = ($urandom % 16 == 0) ? N'($urandom) : '0;
      op = $urandom % 6;
      bus_en = (op != 0);
      bus_we = (op >= 4);
      case ($urandom % 5)
        0: bus_addr = 8'($urandom % 4);
        1, 2: bus_addr = 8'(4 + $urandom % (2*N));
        3: bus_addr = 8'(32 + $urandom % (8*N));
        default: bus_addr = 8'($urandom % 64);
      endcase
      bus_wdata = (bus_addr >= 8'h20) ? 8'($urandom % 24) : 8'($urandom);
    end
    @(negedge clk);
    bus_en = 0; bus_we = 0; cnt_evt = '0;
    ovf_clr = '0; th0_clr = '0; th1_clr = '0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule